// File: doc/BRIEF.md
# Precise Restart PC Pair Capture

This block sits beside the commit point of an in-order pipeline whose branches and jumps have exactly one delay slot. Every instruction that precedes the chosen interrupt point has committed. Neither the interrupting instruction nor anything after it has changed state. When an exception or interrupt is taken, the block records the two program counters that a return-from-trap needs to resume execution correctly.

A single restart PC is not enough on this kind of machine. If the interrupt point is a delay slot, the instruction that follows it is decided by the branch outcome. The block therefore saves a pair of PCs. The first is always the PC of the interrupt point. The second is the next PC in sequence, except when the point is the delay slot of a taken branch; in that case the second PC is the branch target.

The pair is written on the exception strobe and held until a return strobe releases it. An exception that arrives while a pair is still live is reported as a double fault and leaves the pair untouched.

Top module: `rpc_restart_capture`

## Requirements
- R1: After synchronous reset, `pair_valid` and `double_fault` are 0, and both saved PCs are 0.
- R2: When `exc_take` is high and no pair is live, the clock edge loads `restart_pc0` with `point_pc` and sets `pair_valid`. Both changes are visible in the following cycle.
- R3: When the interrupt point is not in a delay slot (`point_in_slot`=0), the captured `restart_pc1` is `point_pc`+4, taken modulo 2^PC_W. This covers both an ordinary instruction and a branch that is itself the interrupt point. `slot_br_taken` and `slot_br_target` have no effect in this case.
- R4: When the interrupt point is the delay slot of a taken branch (`point_in_slot`=1, `slot_br_taken`=1), the captured `restart_pc1` is `slot_br_target`.
- R5: When the interrupt point is the delay slot of a not-taken branch (`point_in_slot`=1, `slot_br_taken`=0), the captured `restart_pc1` is `point_pc`+4, which is the branch PC plus 8. `slot_br_target` has no effect.
- R6: While neither strobe is high, both saved PCs and `pair_valid` keep their values whatever the other inputs do.
- R7: `ret_take` without `exc_take` clears `pair_valid` at the next edge and leaves the saved PCs unchanged. With no live pair it has no visible effect.
- R8: `exc_take` while a pair is live and `ret_take` is low raises `double_fault` for exactly the following cycle. The saved pair and `pair_valid` are left unchanged.
- R9: `exc_take` and `ret_take` in the same cycle while a pair is live capture the new pair. `pair_valid` stays 1 and no double fault is raised.
- R10: `double_fault` is 0 in every cycle that does not directly follow an R8 event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_take | input | 1 | Exception or interrupt is taken at the current interrupt point |
| ret_take | input | 1 | Return from trap; releases the saved pair |
| point_pc | input | PC_W | PC of the instruction at the interrupt point |
| point_in_slot | input | 1 | Interrupt point is a branch delay slot |
| slot_br_taken | input | 1 | Outcome of the branch that owns the delay slot |
| slot_br_target | input | PC_W | Target of the branch that owns the delay slot |
| restart_pc0 | output | PC_W | First saved restart PC |
| restart_pc1 | output | PC_W | Second saved restart PC |
| pair_valid | output | 1 | A saved pair is live |
| double_fault | output | 1 | Exception arrived while a pair was live (one-cycle pulse) |

## Verification
The exception strobe and the return strobe can occur in the same cycle. When they do, the outcome depends on whether a pair is live: a live pair must be replaced with no double fault, and with no pair the strobes must capture as usual. Directed cycles raise both strobes together, once with a live pair and once without. The random phase draws each strobe on its own, so the two overlap often. A bench model predicts the pair, the valid flag and the fault pulse for every cycle, and each output is compared against it.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

    typedef enum logic [1:0] {
        ACT_IDLE    = 2'd0,
        ACT_CAPTURE = 2'd1,
        ACT_DOUBLE  = 2'd2,
        ACT_RELEASE = 2'd3
    } rpc_act_e;

    // The return strobe is applied before a simultaneous exception.
    function automatic rpc_act_e rpc_decide(input logic exc, input logic ret,
                                            input logic live);
        rpc_act_e act;
        if (exc && (!live || ret))
            act = ACT_CAPTURE;
        else if (exc)
            act = ACT_DOUBLE;
        else if (ret)
            act = ACT_RELEASE;
        else
            act = ACT_IDLE;
        return act;
    endfunction

endpackage

// File: rtl/rpc_pair_calc.sv
module rpc_pair_calc #(
    parameter int PC_W        = 32,
    parameter int INSTR_BYTES = 4
) (
    input  logic [PC_W-1:0] point_pc,
    input  logic            in_slot,
    input  logic            br_taken,
    input  logic [PC_W-1:0] br_target,
    output logic [PC_W-1:0] first_pc,
    output logic [PC_W-1:0] second_pc
);
    localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

    logic [PC_W-1:0] seq_pc;

    always_comb begin
        seq_pc   = point_pc + STEP;
        first_pc = point_pc;
        // Only a taken branch's delay slot redirects the follower.
        if (in_slot && br_taken)
            second_pc = br_target;
        else
            second_pc = seq_pc;
    end
endmodule

// File: rtl/rpc_save_reg.sv
module rpc_save_reg
    import rpc_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            exc,
    input  logic            ret,
    input  logic [PC_W-1:0] new_pc0,
    input  logic [PC_W-1:0] new_pc1,
    output logic [PC_W-1:0] pc0,
    output logic [PC_W-1:0] pc1,
    output logic            live,
    output logic            dfault
);
    rpc_act_e act;

    always_comb act = rpc_decide(exc, ret, live);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc0    <= '0;
            pc1    <= '0;
            live   <= 1'b0;
            dfault <= 1'b0;
        end else begin
            dfault <= (act == ACT_DOUBLE);
            unique case (act)
                ACT_CAPTURE: begin
                    pc0  <= new_pc0;
                    pc1  <= new_pc1;
                    live <= 1'b1;
                end
                ACT_RELEASE: live <= 1'b0;
                default: ;
            endcase
        end
    end

    AST_HOLD_PAIR: assert property (@(posedge clk) disable iff (rst)
        (!exc && !ret) |=> ($stable(pc0) && $stable(pc1) && $stable(live))); // R6
    AST_RET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ret && !exc) |=> (!live && $stable(pc0) && $stable(pc1))); // R7
    AST_DOUBLE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (exc && live && !ret) |=> (dfault && live && $stable(pc0) && $stable(pc1))); // R8
    AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (exc && ret) |=> (live && !dfault)); // R9
    AST_NO_SPURIOUS_DF: assert property (@(posedge clk) disable iff (rst)
        !exc |=> !dfault); // R10
endmodule

// File: rtl/rpc_restart_capture.sv
module rpc_restart_capture #(
    parameter int PC_W        = 32,
    parameter int INSTR_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            exc_take,
    input  logic            ret_take,
    input  logic [PC_W-1:0] point_pc,
    input  logic            point_in_slot,
    input  logic            slot_br_taken,
    input  logic [PC_W-1:0] slot_br_target,
    output logic [PC_W-1:0] restart_pc0,
    output logic [PC_W-1:0] restart_pc1,
    output logic            pair_valid,
    output logic            double_fault
);
    logic [PC_W-1:0] cand_pc0;
    logic [PC_W-1:0] cand_pc1;

    rpc_pair_calc #(.PC_W(PC_W), .INSTR_BYTES(INSTR_BYTES)) u_calc (
        .point_pc  (point_pc),
        .in_slot   (point_in_slot),
        .br_taken  (slot_br_taken),
        .br_target (slot_br_target),
        .first_pc  (cand_pc0),
        .second_pc (cand_pc1)
    );

    rpc_save_reg #(.PC_W(PC_W)) u_save (
        .clk     (clk),
        .rst     (rst),
        .exc     (exc_take),
        .ret     (ret_take),
        .new_pc0 (cand_pc0),
        .new_pc1 (cand_pc1),
        .pc0     (restart_pc0),
        .pc1     (restart_pc1),
        .live    (pair_valid),
        .dfault  (double_fault)
    );

    AST_FIRST_IS_POINT: assert property (@(posedge clk) disable iff (rst)
        (exc_take && (!pair_valid || ret_take)) |=>
            (pair_valid && restart_pc0 == $past(point_pc))); // R2
    AST_TAKEN_SLOT: assert property (@(posedge clk) disable iff (rst)
        (exc_take && (!pair_valid || ret_take) && point_in_slot && slot_br_taken) |=>
            (restart_pc1 == $past(slot_br_target))); // R4
    AST_SEQ_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (exc_take && (!pair_valid || ret_take) && !(point_in_slot && slot_br_taken)) |=>
            (restart_pc1 == $past(point_pc) + PC_W'(INSTR_BYTES))); // R3 R5
endmodule

// File: tb/rpc_restart_capture_test.sv
module rpc_restart_capture_test;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         exc = 1'b0, ret = 1'b0, slot = 1'b0, tkn = 1'b0;
    logic [W-1:0] pc = '0, tgt = '0;
    logic [W-1:0] pc0, pc1;
    logic         valid, df;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    // bench model
    logic [W-1:0] m_pc0 = '0, m_pc1 = '0;
    logic         m_valid = 0, m_df = 0;
    string        tag = "R1";

    always #2 clk = ~clk;

    rpc_restart_capture #(.PC_W(W), .INSTR_BYTES(4)) uut (
        .clk(clk), .rst(rst), .exc_take(exc), .ret_take(ret),
        .point_pc(pc), .point_in_slot(slot), .slot_br_taken(tkn),
        .slot_br_target(tgt), .restart_pc0(pc0), .restart_pc1(pc1),
        .pair_valid(valid), .double_fault(df));

    function automatic logic [W-1:0] exp_second(logic [W-1:0] p, logic s,
                                                logic t, logic [W-1:0] g);
        return (s && t) ? g : p + 32'd4;
    endfunction

    function automatic string pick_tag(logic e, logic r, logic v, logic s, logic t);
        if (e && r && v) return "R9";
        if (e && v)      return "R8";
        if (e && s && t) return "R4";
        if (e && s)      return "R5";
        if (e)           return "R3";
        if (r)           return "R7";
        return "R6";
    endfunction

    task automatic chk(string t, string what, logic [W-1:0] got, logic [W-1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", t, what, got, exp);
        end
    endtask

    task automatic compare_all();
        chk(tag, "pc0", pc0, m_pc0);
        chk(tag, "pc1", pc1, m_pc1);
        chk(tag, "valid", {31'd0, valid}, {31'd0, m_valid});
        chk((tag == "R8") ? "R8" : "R10", "dfault", {31'd0, df}, {31'd0, m_df});
    endtask

    // apply one cycle of stimulus and advance the model
    task automatic cyc(logic e, logic r, logic [W-1:0] p, logic s, logic t, logic [W-1:0] g);
        exc = e; ret = r; pc = p; slot = s; tkn = t; tgt = g;
        tag = pick_tag(e, r, m_valid, s, t);
        m_df = e && m_valid && !r;
        if (e && (!m_valid || r)) begin
            m_pc0 = p; m_pc1 = exp_second(p, s, t, g); m_valid = 1;
        end else if (r && !e) begin
            m_valid = 0;
        end
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        if (!finished) begin
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int seed = 32'h5eed_1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst = 0;
        tag = "R1";
        compare_all();
        // R3: ordinary point, taken flag and target must not matter
        cyc(1, 0, 32'h0000_1000, 0, 1, 32'h0000_9000);
        tag = "R2"; chk("R2", "pc0", pc0, 32'h0000_1000);
        chk("R3", "pc1", pc1, 32'h0000_1004);
        // R6: inputs wander, no strobes
        cyc(0, 0, 32'hdead_beef, 1, 1, 32'h1234_5678);
        // R8: double fault keeps the pair
        cyc(1, 0, 32'h0000_2000, 1, 1, 32'h0000_3000);
        cyc(0, 0, 32'h0, 0, 0, 32'h0);
        // R7: release
        cyc(0, 1, 32'h0, 0, 0, 32'h0);
        cyc(0, 1, 32'h0, 0, 0, 32'h0);
        // R4: taken-branch delay slot
        cyc(1, 0, 32'h0000_4004, 1, 1, 32'h0000_8000);
        // R9: both strobes with a live pair, not-taken slot (R5)
        cyc(1, 1, 32'h0000_5004, 1, 0, 32'h0000_7000);
        chk("R5", "pc1", pc1, 32'h0000_5008);
        cyc(0, 1, 32'h0, 0, 0, 32'h0);
        // both strobes, no live pair: plain capture; wrap of PC+4 (R3)
        cyc(1, 1, 32'hffff_fffc, 0, 0, 32'h0);
        chk("R3", "wrap", pc1, 32'h0000_0000);
        cyc(0, 1, 32'h0, 0, 0, 32'h0);
        for (int i = 0; i < 4000; i++) begin
            cyc(($urandom % 3) == 0, ($urandom % 3) == 0, $urandom & 32'hffff_fffc,
                $urandom % 2, $urandom % 2, $urandom & 32'hffff_fffc);
        end
        // reset mid-run returns to R1 state
        rst = 1; exc = 0; ret = 0;
        @(negedge clk);
        rst = 0;
        m_pc0 = '0; m_pc1 = '0; m_valid = 0; m_df = 0; tag = "R1";
        compare_all();
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule